// File: doc/BRIEF.md
# Absolute-Mode Bus Cycle Sequencer

This block steps an 8/16-bit accumulator processor through a small family of absolute addressing modes. It runs one bus cycle per clock on a byte-wide memory port. Each cycle is one of six kinds: an opcode fetch, an operand fetch from the program stream, a data read, a data write, a stack push, or an internal idle cycle. After the opcode byte, two operand bytes follow, and together they form a 16-bit address. What happens next depends on the opcode:

- For a read, the block fetches one or two data bytes and hands them to an external execute unit.
- For a write, it puts an externally supplied value on the bus.
- For a jump, it reloads the program counter, either directly or through a pointer table that is indexed by an X value.
- For a subroutine call, it pushes a return address and then reloads the program counter.

The memory answers in the same cycle in which it sees the address. A width flag, sampled while the opcode is fetched, selects whether a data transfer is one byte or two. The block does not implement the ALU, other addressing modes or interrupts. Any opcode it does not know behaves as a single-cycle no-operation.

Top module: `abs_cycle_seq`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, the bus shows an opcode fetch (`busKind`=0, `sync`=1, `memWe`=0) at the parameter `RESET_PC`. The first stack push after reset goes to the parameter `STACK_TOP`.
- R2: An opcode fetch lasts exactly one cycle. In that cycle `sync`=1, `busKind`=0 and `memWe`=0, and the address is the program counter. The next cycle continues at the program counter plus one. `sync` is low in every other cycle.
- R3: The absolute reads are opcodes 0x0D, 0x2C, 0x2D, 0x4D, 0x6D, 0xAC, 0xAD, 0xAE, 0xCC, 0xCD, 0xEC and 0xED. Each runs the following cycles:
  - two operand fetches (`busKind`=1) at PC+1 and PC+2, low byte first;
  - a data read (`busKind`=2) at {high,low};
  - in 16-bit mode only, a second read at that address plus one, wrapping at 16 bits.
  
  The next opcode fetch is at PC+3. In that fetch cycle `execValid` is 1 for one cycle, `execOpcode` holds the opcode and `execOperand` holds {high data byte, low data byte}. In 8-bit mode the high byte is 0.
- R4: The absolute writes are opcodes 0x8C, 0x8D, 0x8E and 0x9C. They fetch their operands the same way as R3, then write (`busKind`=3, `memWe`=1) `storeData[7:0]` at the address. In 16-bit mode they then write `storeData[15:8]` at the address plus one. Opcode 0x9C writes zero bytes instead. No `execValid` follows a write.
- R5: Opcode 0x4C takes three cycles: the fetch, then operand fetches at PC+1 and PC+2. The next opcode fetch is at {high,low}.
- R6: Opcode 0x20 runs these cycles:
  1. operand fetches at PC+1 and PC+2;
  2. an idle cycle (`busKind`=5) at PC+2;
  3. a push (`busKind`=4, `memWe`=1) of the high byte of PC+2 at the stack pointer;
  4. a push of its low byte at the stack pointer minus one.
  
  The next opcode fetch is at {high,low}.
- R7: Opcode 0x7C runs these cycles:
  1. operand fetches at PC+1 and PC+2;
  2. an idle cycle at PC+2;
  3. reads (`busKind`=2) at P = {high,low} + `xIndex` and at P+1, both modulo 2^16.
  
  The next opcode fetch is at {byte read at P+1, byte read at P}.
- R8: Any other opcode takes only its fetch cycle. The next opcode fetch is at PC+1, and no `execValid` follows it.
- R9: `memWe` is 1 only in cycles whose `busKind` is 3 (write) or 4 (push).
- R10: The width flag is sampled only in the opcode fetch cycle. Changes to it later in the same instruction have no effect.
- R11: Every push lowers the stack pointer by one. Consecutive subroutine calls push to addresses that continue downward without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wide | input | 1 | 1 selects 16-bit data transfers, sampled at opcode fetch |
| xIndex | input | 16 | Index value added to the pointer of the indexed indirect jump |
| storeData | input | 16 | Value written by the absolute write opcodes |
| memRdata | input | 8 | Read data for the current address, same cycle |
| memAddr | output | 16 | Bus address of the current cycle |
| memWdata | output | 8 | Write data of the current cycle |
| memWe | output | 1 | Write enable, high in write and push cycles |
| sync | output | 1 | High in opcode fetch cycles |
| busKind | output | 3 | Cycle kind: 0 opcode, 1 operand, 2 read, 3 write, 4 push, 5 idle |
| execValid | output | 1 | One-cycle pulse: a read operand is ready |
| execOpcode | output | 8 | Opcode belonging to the operand on execOperand |
| execOperand | output | 16 | Fetched data operand |

## Verification
The assertions assume three things about the inputs:
- `memRdata` is a pure function of the address presented in the same cycle;
- reset is held low for at least one clock edge before it is released;
- `xIndex` and `storeData` stay constant from the fetch of an instruction to its last cycle.

The stimulus respects these assumptions. It models memory as a byte store that is read combinationally and updated only by the expected write and push cycles. It changes `xIndex` and `storeData` only at the opcode fetch. It places program code, pointer tables and the stack in separate address ranges, so that no write can alter bytes the running instruction still has to fetch. The width flag is deliberately randomised after the fetch.

// File: rtl/abs_seq_pkg.sv
package abs_seq_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    BK_OPCODE  = 3'd0,
    BK_OPERAND = 3'd1,
    BK_READ    = 3'd2,
    BK_WRITE   = 3'd3,
    BK_PUSH    = 3'd4,
    BK_IDLE    = 3'd5
  } busKind_e;

  typedef enum logic [2:0] {
    OC_NONE, OC_READ, OC_WRITE, OC_JMP, OC_JSR, OC_JMPIX
  } opClass_e;

  typedef enum logic [1:0] {A_PC, A_DATA, A_DATA1, A_SP} addrSel_e;

  typedef enum logic [2:0] {W_STORE_LO, W_STORE_HI, W_ZERO, W_PCH, W_PCL} wdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     pcInc;
    logic     pcLoadRd;
    logic     pcLoadAddr;
    logic     latchOpLo;
    logic     addrLoadAbs;
    logic     addrAddX;
    logic     bufLo;
    logic     bufHi;
    logic     spDec;
    addrSel_e addrSel;
    wdSel_e   wdSel;
  } strobes_t;

  localparam logic [BYTE_W-1:0] OP_STZ = 8'h9C;

  function automatic opClass_e classify(input logic [BYTE_W-1:0] op);
    case (op)
      8'h0D, 8'h2C, 8'h2D, 8'h4D, 8'h6D, 8'hCD,
      8'hED, 8'hAC, 8'hAD, 8'hAE, 8'hCC, 8'hEC: classify = OC_READ;
      8'h8C, 8'h8D, 8'h8E, 8'h9C:               classify = OC_WRITE;
      8'h4C:                                    classify = OC_JMP;
      8'h20:                                    classify = OC_JSR;
      8'h7C:                                    classify = OC_JMPIX;
      default:                                  classify = OC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/abs_seq_dpath.sv
module abs_seq_dpath
  import abs_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC  = 16'h4000,
  parameter logic [ADDR_W-1:0] STACK_TOP = 16'h01FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [BYTE_W-1:0]   memRdata,
  input  logic [ADDR_W-1:0]   xIndex,
  input  logic [2*BYTE_W-1:0] storeData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BYTE_W-1:0]   memWdata,
  output logic [2*BYTE_W-1:0] dataBuf
);

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] sp;
  logic [ADDR_W-1:0] dataAddr;
  logic [BYTE_W-1:0] opLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= RESET_PC;
      sp       <= STACK_TOP;
      dataAddr <= '0;
      opLo     <= '0;
      dataBuf  <= '0;
    end else begin
      if (stb.pcLoadRd)        pc <= {memRdata, opLo};
      else if (stb.pcLoadAddr) pc <= dataAddr;
      else if (stb.pcInc)      pc <= pc + ADDR_W'(1);

      if (stb.spDec)     sp   <= sp - ADDR_W'(1);
      if (stb.latchOpLo) opLo <= memRdata;

      if (stb.addrLoadAbs)   dataAddr <= {memRdata, opLo};
      else if (stb.addrAddX) dataAddr <= dataAddr + xIndex;

      if (stb.bufLo) dataBuf <= {{BYTE_W{1'b0}}, memRdata};
      if (stb.bufHi) dataBuf[2*BYTE_W-1:BYTE_W] <= memRdata;
    end
  end

  always_comb begin
    case (stb.addrSel)
      A_DATA:  memAddr = dataAddr;
      A_DATA1: memAddr = dataAddr + ADDR_W'(1);
      A_SP:    memAddr = sp;
      default: memAddr = pc;
    endcase
  end

  always_comb begin
    case (stb.wdSel)
      W_STORE_HI: memWdata = storeData[2*BYTE_W-1:BYTE_W];
      W_ZERO:     memWdata = '0;
      W_PCH:      memWdata = pc[ADDR_W-1:ADDR_W-BYTE_W];
      W_PCL:      memWdata = pc[BYTE_W-1:0];
      default:    memWdata = storeData[BYTE_W-1:0];
    endcase
  end

endmodule

// File: rtl/abs_seq_ctrl.sv
module abs_seq_ctrl
  import abs_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic              wide,
  output strobes_t          stb,
  output busKind_e          busKind,
  output logic              memWe,
  output logic              sync,
  output logic              execValid,
  output logic [BYTE_W-1:0] opcode
);

  typedef enum logic [3:0] {
    S_FETCH, S_OPL, S_OPH, S_IO, S_DLO, S_DHI,
    S_PUSHH, S_PUSHL, S_INDL, S_INDH
  } state_e;

  state_e   state;
  state_e   stateNext;
  opClass_e cls;
  logic     wideQ;
  logic     execNext;
  logic     isStz;

  assign cls   = classify(opcode);
  assign isStz = (opcode == OP_STZ);

  always_comb begin
    stb       = '0;
    stateNext = state;
    busKind   = BK_IDLE;
    memWe     = 1'b0;
    sync      = 1'b0;
    execNext  = 1'b0;
    case (state)
      S_FETCH: begin
        busKind   = BK_OPCODE;
        sync      = 1'b1;
        stb.pcInc = 1'b1;
        stateNext = (classify(memRdata) == OC_NONE) ? S_FETCH : S_OPL;
      end
      S_OPL: begin
        busKind       = BK_OPERAND;
        stb.pcInc     = 1'b1;
        stb.latchOpLo = 1'b1;
        stateNext     = S_OPH;
      end
      S_OPH: begin
        busKind         = BK_OPERAND;
        stb.addrLoadAbs = 1'b1;
        case (cls)
          OC_READ, OC_WRITE: begin
            stb.pcInc = 1'b1;
            stateNext = S_DLO;
          end
          OC_JMP: begin
            stb.pcLoadRd = 1'b1;
            stateNext    = S_FETCH;
          end
          OC_JSR, OC_JMPIX: stateNext = S_IO;
          default:          stateNext = S_FETCH;
        endcase
      end
      S_IO: begin
        busKind = BK_IDLE;
        if (cls == OC_JMPIX) begin
          stb.addrAddX = 1'b1;
          stateNext    = S_INDL;
        end else begin
          stateNext = S_PUSHH;
        end
      end
      S_DLO: begin
        stb.addrSel = A_DATA;
        if (cls == OC_WRITE) begin
          busKind   = BK_WRITE;
          memWe     = 1'b1;
          stb.wdSel = isStz ? W_ZERO : W_STORE_LO;
        end else begin
          busKind   = BK_READ;
          stb.bufLo = 1'b1;
          execNext  = !wideQ;
        end
        stateNext = wideQ ? S_DHI : S_FETCH;
      end
      S_DHI: begin
        stb.addrSel = A_DATA1;
        if (cls == OC_WRITE) begin
          busKind   = BK_WRITE;
          memWe     = 1'b1;
          stb.wdSel = isStz ? W_ZERO : W_STORE_HI;
        end else begin
          busKind   = BK_READ;
          stb.bufHi = 1'b1;
          execNext  = 1'b1;
        end
        stateNext = S_FETCH;
      end
      S_PUSHH: begin
        busKind     = BK_PUSH;
        memWe       = 1'b1;
        stb.addrSel = A_SP;
        stb.wdSel   = W_PCH;
        stb.spDec   = 1'b1;
        stateNext   = S_PUSHL;
      end
      S_PUSHL: begin
        busKind        = BK_PUSH;
        memWe          = 1'b1;
        stb.addrSel    = A_SP;
        stb.wdSel      = W_PCL;
        stb.spDec      = 1'b1;
        stb.pcLoadAddr = 1'b1;
        stateNext      = S_FETCH;
      end
      S_INDL: begin
        busKind       = BK_READ;
        stb.addrSel   = A_DATA;
        stb.latchOpLo = 1'b1;
        stateNext     = S_INDH;
      end
      S_INDH: begin
        busKind      = BK_READ;
        stb.addrSel  = A_DATA1;
        stb.pcLoadRd = 1'b1;
        stateNext    = S_FETCH;
      end
      default: stateNext = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_FETCH;
      opcode    <= '0;
      wideQ     <= 1'b0;
      execValid <= 1'b0;
    end else begin
      state     <= stateNext;
      execValid <= execNext;
      if (state == S_FETCH) begin
        opcode <= memRdata;
        wideQ  <= wide;
      end
    end
  end

endmodule

// File: rtl/abs_cycle_seq.sv
module abs_cycle_seq
  import abs_seq_pkg::*;
#(
  parameter logic [15:0] RESET_PC  = 16'h4000,
  parameter logic [15:0] STACK_TOP = 16'h01FF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wide,
  input  logic [15:0] xIndex,
  input  logic [15:0] storeData,
  input  logic [7:0]  memRdata,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  output logic        memWe,
  output logic        sync,
  output logic [2:0]  busKind,
  output logic        execValid,
  output logic [7:0]  execOpcode,
  output logic [15:0] execOperand
);

  strobes_t stb;
  busKind_e kindE;

  abs_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .memRdata  (memRdata),
    .wide      (wide),
    .stb       (stb),
    .busKind   (kindE),
    .memWe     (memWe),
    .sync      (sync),
    .execValid (execValid),
    .opcode    (execOpcode)
  );

  abs_seq_dpath #(
    .RESET_PC  (RESET_PC),
    .STACK_TOP (STACK_TOP)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .memRdata  (memRdata),
    .xIndex    (xIndex),
    .storeData (storeData),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .dataBuf   (execOperand)
  );

  assign busKind = kindE;

endmodule

// File: rtl/abs_seq_checker.sv
module abs_seq_checker #(
  parameter logic [15:0] RESET_PC = 16'h4000
) (
  input logic        clk,
  input logic        rstN,
  input logic        sync,
  input logic        memWe,
  input logic [2:0]  busKind,
  input logic [15:0] memAddr,
  input logic        execValid
);

  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (sync && memAddr == RESET_PC));

  assert_sync_nowrite_R2: assert property (@(posedge clk) disable iff (!rstN)
    sync |-> (!memWe && busKind == 3'd0));

  assert_exec_at_fetch_R3: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> sync);

  assert_read_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    busKind == 3'd2 |=> (sync || (busKind == 3'd2 && memAddr == 16'($past(memAddr) + 16'd1))));

  assert_write_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    busKind == 3'd3 |=> (sync || (busKind == 3'd3 && memAddr == 16'($past(memAddr) + 16'd1))));

  assert_we_kind_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (busKind == 3'd3 || busKind == 3'd4));

  assert_push_pair_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busKind == 3'd4 && $past(busKind) == 3'd5) |=>
      (busKind == 3'd4 && memAddr == 16'($past(memAddr) - 16'd1)));

endmodule

bind abs_cycle_seq abs_seq_checker #(.RESET_PC(RESET_PC)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .sync      (sync),
  .memWe     (memWe),
  .busKind   (busKind),
  .memAddr   (memAddr),
  .execValid (execValid)
);

// File: tb/tb_abs_cycle_seq.sv
module tb_abs_cycle_seq;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] RST_PC     = 16'h4000;
  localparam logic [15:0] SP_TOP     = 16'h01FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wide = 1'b0;
  logic [15:0] xIndex = '0;
  logic [15:0] storeData = '0;
  logic [7:0]  memRdata;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe, sync, execValid;
  logic [2:0]  busKind;
  logic [7:0]  execOpcode;
  logic [15:0] execOperand;

  abs_cycle_seq #(.RESET_PC(RST_PC), .STACK_TOP(SP_TOP)) dut (
    .clk(clk), .rstN(rstN), .wide(wide), .xIndex(xIndex), .storeData(storeData),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .sync(sync), .busKind(busKind), .execValid(execValid),
    .execOpcode(execOpcode), .execOperand(execOperand)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // byte store, combinational read
  logic [7:0] mem [int];
  int memVer = 0;

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(memAddr or memVer) memRdata = rd(memAddr);

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    mem[int'(a)] = d;
    memVer++;
  endtask

  int errs = 0;
  int checks = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one bus cycle: wait mid-cycle, compare {kind, addr, we, sync, wdata, execValid}
  task automatic cyc(input string req, input logic [2:0] kind, input logic [15:0] addr,
                     input logic we, input logic [7:0] wd, input logic isSync, input logic ex);
    logic [29:0] a, e;
    @(negedge clk);
    a = {busKind, memAddr, memWe, sync, (memWe ? memWdata : 8'h00), execValid};
    e = {kind, addr, we, isSync, (we ? wd : 8'h00), ex};
    chk(req, "cycle", 32'(a), 32'(e));
    if (we) wr(addr, wd);
  endtask

  // bench-side opcode classes: 0 none, 1 read, 2 write, 3 jmp, 4 jsr, 5 indexed indirect jmp
  function automatic int benchClass(input logic [7:0] op);
    case (op)
      8'hAD, 8'hAE, 8'hAC, 8'h6D, 8'hED, 8'hCD,
      8'hEC, 8'hCC, 8'h0D, 8'h2D, 8'h4D, 8'h2C: return 1;
      8'h8D, 8'h8E, 8'h8C, 8'h9C:               return 2;
      8'h4C: return 3;
      8'h20: return 4;
      8'h7C: return 5;
      default: return 0;
    endcase
  endfunction

  logic [15:0] expPc = RST_PC;
  logic [15:0] expSp = SP_TOP;
  logic        pendExec = 1'b0;
  logic [7:0]  pendOp = '0;
  logic [15:0] pendVal = '0;

  task automatic runInstr(input string req, input logic [7:0] op, input logic [15:0] oper,
                          input logic w, input logic [15:0] x, input logic [15:0] st,
                          input logic [15:0] tgt);
    int c;
    logic [15:0] pc0, ptr, ret;
    logic [7:0]  lo, hi;
    c   = benchClass(op);
    pc0 = expPc;
    ptr = 16'(oper + x);
    wr(pc0, op);
    wr(16'(pc0 + 16'd1), oper[7:0]);
    wr(16'(pc0 + 16'd2), oper[15:8]);
    if (c == 5) begin
      wr(ptr, tgt[7:0]);
      wr(16'(ptr + 16'd1), tgt[15:8]);
    end
    cyc(req, 3'd0, pc0, 1'b0, 8'h00, 1'b1, pendExec);
    if (pendExec) chk("R3", "exec opcode/operand", {8'h00, pendOp, pendVal}, {8'h00, execOpcode, execOperand});
    pendExec  = 1'b0;
    wide      = w;
    xIndex    = x;
    storeData = st;
    if (c == 0) begin
      expPc = 16'(pc0 + 16'd1);
      return;
    end
    cyc(req, 3'd1, 16'(pc0 + 16'd1), 1'b0, 8'h00, 1'b0, 1'b0);
    wide = 1'($urandom);  // R10: width flag changes after the fetch must not matter
    cyc(req, 3'd1, 16'(pc0 + 16'd2), 1'b0, 8'h00, 1'b0, 1'b0);
    case (c)
      1: begin
        pendVal = w ? {rd(16'(oper + 16'd1)), rd(oper)} : {8'h00, rd(oper)};
        cyc(req, 3'd2, oper, 1'b0, 8'h00, 1'b0, 1'b0);
        if (w) cyc(req, 3'd2, 16'(oper + 16'd1), 1'b0, 8'h00, 1'b0, 1'b0);
        pendExec = 1'b1;
        pendOp   = op;
        expPc    = 16'(pc0 + 16'd3);
      end
      2: begin
        lo = (op == 8'h9C) ? 8'h00 : st[7:0];
        hi = (op == 8'h9C) ? 8'h00 : st[15:8];
        cyc(req, 3'd3, oper, 1'b1, lo, 1'b0, 1'b0);
        if (w) cyc(req, 3'd3, 16'(oper + 16'd1), 1'b1, hi, 1'b0, 1'b0);
        expPc = 16'(pc0 + 16'd3);
      end
      3: expPc = oper;
      4: begin
        ret = 16'(pc0 + 16'd2);
        cyc(req, 3'd5, ret, 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(req, 3'd4, expSp, 1'b1, ret[15:8], 1'b0, 1'b0);
        cyc(req, 3'd4, 16'(expSp - 16'd1), 1'b1, ret[7:0], 1'b0, 1'b0);
        expSp = 16'(expSp - 16'd2);
        expPc = oper;
      end
      default: begin
        cyc(req, 3'd5, 16'(pc0 + 16'd2), 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(req, 3'd2, ptr, 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(req, 3'd2, 16'(ptr + 16'd1), 1'b0, 8'h00, 1'b0, 1'b0);
        expPc = tgt;
      end
    endcase
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  logic [7:0] readOps  [12] = '{8'h0D, 8'h2C, 8'h2D, 8'h4D, 8'h6D, 8'hCD,
                                8'hED, 8'hAC, 8'hAD, 8'hAE, 8'hCC, 8'hEC};
  logic [7:0] writeOps [4]  = '{8'h8C, 8'h8D, 8'h8E, 8'h9C};

  initial begin
    int jsrCount;
    logic [7:0] op;
    logic [15:0] ptrR, xR;
    jsrCount = 0;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while held in reset
    chk("R1", "reset bus", {13'd0, busKind, memAddr}, {13'd0, 3'd0, RST_PC});
    chk("R1", "reset sync/we", {30'd0, sync, memWe}, {30'd0, 1'b1, 1'b0});
    @(posedge clk);
    #1 rstN = 1'b1;

    // directed corner cases
    runInstr("R8", 8'hEA, 16'h0000, 1'b0, 16'h0, 16'h0, 16'h0);
    runInstr("R3", 8'hAD, 16'h1234, 1'b0, 16'h0, 16'h0, 16'h0);
    runInstr("R3", 8'hAD, 16'h2222, 1'b1, 16'h0, 16'h0, 16'h0);
    runInstr("R3", 8'hCD, 16'hFFFF, 1'b1, 16'h0, 16'h0, 16'h0);
    runInstr("R4", 8'h8D, 16'h3000, 1'b1, 16'h0, 16'hBEEF, 16'h0);
    runInstr("R4", 8'h9C, 16'h3100, 1'b1, 16'h0, 16'h1234, 16'h0);
    runInstr("R4", 8'h8E, 16'h3200, 1'b0, 16'h0, 16'hA55A, 16'h0);
    runInstr("R6", 8'h20, 16'h6000, 1'b0, 16'h0, 16'h0, 16'h0);
    runInstr("R11", 8'h20, 16'h7000, 1'b0, 16'h0, 16'h0, 16'h0);
    runInstr("R5", 8'h4C, 16'h5000, 1'b0, 16'h0, 16'h0, 16'h0);
    runInstr("R7", 8'h7C, 16'h2FF0, 1'b0, 16'h0010, 16'h0, 16'h8000);
    runInstr("R7", 8'h7C, 16'hFFF0, 1'b1, 16'h000F, 16'h0, 16'h9000);
    runInstr("R8", 8'h6C, 16'h1111, 1'b0, 16'h0, 16'h0, 16'h0);
    runInstr("R10", 8'hAE, 16'h0100, 1'b0, 16'h0, 16'h0, 16'h0);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int t;
      t = int'($urandom % 6);
      if (t == 4 && jsrCount >= 60) t = 1;
      case (t)
        0: begin
          op = 8'($urandom);
          while (benchClass(op) != 0) op = 8'($urandom);
          runInstr("R8", op, 16'($urandom), 1'($urandom), 16'h0, 16'h0, 16'h0);
        end
        1: runInstr("R3", readOps[$urandom % 12], 16'($urandom), 1'($urandom), 16'h0, 16'h0, 16'h0);
        2: runInstr("R4", writeOps[$urandom % 4], 16'($urandom), 1'($urandom), 16'h0, 16'($urandom), 16'h0);
        3: runInstr("R5", 8'h4C, 16'(16'h4000 + ($urandom % 32'hB000)), 1'b0, 16'h0, 16'h0, 16'h0);
        4: begin
          jsrCount++;
          runInstr("R6", 8'h20, 16'(16'h4000 + ($urandom % 32'hB000)), 1'b0, 16'h0, 16'h0, 16'h0);
        end
        default: begin
          ptrR = 16'(16'h2000 + ($urandom % 32'h1FFE));
          xR   = 16'($urandom);
          runInstr("R7", 8'h7C, 16'(ptrR - xR), 1'($urandom), xR, 16'h0,
                   16'(16'h4000 + ($urandom % 32'hB000)));
        end
      endcase
    end
    // final fetch flushes any pending operand hand-off (R2)
    runInstr("R2", 8'hEA, 16'h0000, 1'b0, 16'h0, 16'h0, 16'h0);
    summary();
    $finish;
  end

endmodule